// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits between the fetch, decode and execute stages of a five-stage pipeline. It finds the one case that forwarding cannot cover. That case arises when a load is in the execute stage and the instruction in the decode stage reads the register the load is about to write. The loaded word does not leave memory until one cycle later, so the decode-stage instruction must wait one cycle.

A single match signal drives three actions in the same cycle. The program counter keeps its value. The fetch/decode register keeps its instruction and that instruction's address. The control fields written into the decode/execute register are all forced to zero, so an empty slot moves down the pipeline. The load is not held and moves on to the memory stage. On the next cycle the empty slot sits in the execute stage, the comparison is false, and the waiting instruction proceeds. Its operand then comes from the memory/writeback forwarding path, which lies outside this block.

The stall output is combinational from the current pipeline-register contents and takes effect at the next rising clock edge. The reset input is asynchronous and active-low. Reset clears the program counter, the fetch/decode register and every execute-stage control field to zero.

Top module: `load_use_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first check after it is released, `pc_o`, `ifid_instr_o`, `ifid_pc_o`, `idex_ex_ctrl_o`, `idex_mem_ctrl_o` and `idex_wb_ctrl_o` are all zero.
- R2: `stall_o` is 1 exactly when `ld_mem_read_i` is 1 and `ld_dest_i` equals `dec_src_a_i` or `dec_src_b_i`. It is 0 when the memory-read flag is 0, even if the indices match.
- R3: At a rising edge while `stall_o` is 1, `pc_o` keeps its value.
- R4: At a rising edge while `stall_o` is 1, `ifid_instr_o` and `ifid_pc_o` keep their values.
- R5: At a rising edge while `stall_o` is 1, all three execute-stage control outputs become zero, whatever the decoded control inputs are.
- R6: At a rising edge while `stall_o` is 0, `pc_o` takes `pc_next_i`, `ifid_instr_o` takes `fetch_instr_i`, `ifid_pc_o` takes the previous `pc_o`, and each control output takes its decoded input.
- R7: Register index 0 is compared like any other index. A load whose destination is index 0 still causes a stall when a decode source names index 0.
- R8: A load followed by two dependent instructions gives exactly one stall cycle. Once the empty slot stands in the execute stage (memory-read flag 0), both dependent instructions advance without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_mem_read_i | input | 1 | Memory-read flag of the instruction in the execute stage |
| ld_dest_i | input | REG_IDX_W | Destination register index of that instruction |
| dec_src_a_i | input | REG_IDX_W | First source index of the instruction in decode |
| dec_src_b_i | input | REG_IDX_W | Second source index of the instruction in decode |
| pc_next_i | input | PC_W | Next fetch address |
| fetch_instr_i | input | INSTR_W | Instruction fetched at `pc_o` |
| dec_ex_ctrl_i | input | EX_CTRL_W | Decoded execute-stage control bits |
| dec_mem_ctrl_i | input | MEM_CTRL_W | Decoded memory-stage control bits |
| dec_wb_ctrl_i | input | WB_CTRL_W | Decoded writeback-stage control bits |
| pc_o | output | PC_W | Program counter |
| ifid_instr_o | output | INSTR_W | Fetch/decode register instruction |
| ifid_pc_o | output | PC_W | Fetch/decode register address |
| idex_ex_ctrl_o | output | EX_CTRL_W | Decode/execute register execute controls |
| idex_mem_ctrl_o | output | MEM_CTRL_W | Decode/execute register memory controls |
| idex_wb_ctrl_o | output | WB_CTRL_W | Decode/execute register writeback controls |
| stall_o | output | 1 | Load-use stall, active this cycle |

## Verification
The bench uses the default parameters: 5-bit register indices, a 32-bit PC and instruction, and control fields of 4, 3 and 2 bits. The 5-bit index width lets the bench compare at both ends of the index range, 0 and 31, and exercise each source port alone and both together. The full-width PC and instruction let the bench use values that show a held register apart from one that was reloaded. The separate control fields show that the empty slot clears every control bit, not only those in one stage's field.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int unsigned REG_IDX_W_DEF  = 5;
  localparam int unsigned PC_W_DEF       = 32;
  localparam int unsigned INSTR_W_DEF    = 32;
  localparam int unsigned EX_CTRL_W_DEF  = 4;
  localparam int unsigned MEM_CTRL_W_DEF = 3;
  localparam int unsigned WB_CTRL_W_DEF  = 2;

  typedef enum logic {
    ADV_FLOW = 1'b0,
    ADV_HOLD = 1'b1
  } adv_e;
endpackage

// File: rtl/lus_detect.sv
module lus_detect #(
  parameter int unsigned IDX_W = lus_pkg::REG_IDX_W_DEF
) (
  input  logic             mem_read_i,
  input  logic [IDX_W-1:0] dest_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  output lus_pkg::adv_e    adv_o
);
  logic hit_a;
  logic hit_b;

  always_comb begin
    hit_a = (dest_i == src_a_i);
    hit_b = (dest_i == src_b_i);
    adv_o = (mem_read_i && (hit_a || hit_b)) ? lus_pkg::ADV_HOLD
                                             : lus_pkg::ADV_FLOW;
  end
endmodule

// File: rtl/lus_hold_reg.sv
module lus_hold_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lus_bubble_reg.sv
module lus_bubble_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  always_comb begin
    q_d = kill_i ? '0 : d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/load_use_stall_ctrl.sv
module load_use_stall_ctrl #(
  parameter int unsigned REG_IDX_W  = lus_pkg::REG_IDX_W_DEF,
  parameter int unsigned PC_W       = lus_pkg::PC_W_DEF,
  parameter int unsigned INSTR_W    = lus_pkg::INSTR_W_DEF,
  parameter int unsigned EX_CTRL_W  = lus_pkg::EX_CTRL_W_DEF,
  parameter int unsigned MEM_CTRL_W = lus_pkg::MEM_CTRL_W_DEF,
  parameter int unsigned WB_CTRL_W  = lus_pkg::WB_CTRL_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_mem_read_i,
  input  logic [REG_IDX_W-1:0]  ld_dest_i,
  input  logic [REG_IDX_W-1:0]  dec_src_a_i,
  input  logic [REG_IDX_W-1:0]  dec_src_b_i,
  input  logic [PC_W-1:0]       pc_next_i,
  input  logic [INSTR_W-1:0]    fetch_instr_i,
  input  logic [EX_CTRL_W-1:0]  dec_ex_ctrl_i,
  input  logic [MEM_CTRL_W-1:0] dec_mem_ctrl_i,
  input  logic [WB_CTRL_W-1:0]  dec_wb_ctrl_i,
  output logic [PC_W-1:0]       pc_o,
  output logic [INSTR_W-1:0]    ifid_instr_o,
  output logic [PC_W-1:0]       ifid_pc_o,
  output logic [EX_CTRL_W-1:0]  idex_ex_ctrl_o,
  output logic [MEM_CTRL_W-1:0] idex_mem_ctrl_o,
  output logic [WB_CTRL_W-1:0]  idex_wb_ctrl_o,
  output logic                  stall_o
);
  localparam int unsigned CTRL_W  = EX_CTRL_W + MEM_CTRL_W + WB_CTRL_W;
  localparam int unsigned FETCH_W = INSTR_W + PC_W;

  lus_pkg::adv_e          adv;
  logic                   flow_en;
  logic [FETCH_W-1:0]     fetch_d;
  logic [FETCH_W-1:0]     fetch_q;
  logic [CTRL_W-1:0]      ctrl_d;
  logic [CTRL_W-1:0]      ctrl_q;

  lus_detect #(.IDX_W(REG_IDX_W)) i_detect (
    .mem_read_i (ld_mem_read_i),
    .dest_i     (ld_dest_i),
    .src_a_i    (dec_src_a_i),
    .src_b_i    (dec_src_b_i),
    .adv_o      (adv)
  );

  assign stall_o = (adv == lus_pkg::ADV_HOLD);
  assign flow_en = ~stall_o;

  // Program counter, frozen during a stall.
  lus_hold_reg #(.W(PC_W)) i_pc_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (flow_en),
    .d_i   (pc_next_i),
    .q_o   (pc_o)
  );

  // Fetch/decode register: instruction and its address.
  assign fetch_d = {fetch_instr_i, pc_o};

  lus_hold_reg #(.W(FETCH_W)) i_ifid_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (flow_en),
    .d_i   (fetch_d),
    .q_o   (fetch_q)
  );

  assign ifid_instr_o = fetch_q[FETCH_W-1:PC_W];
  assign ifid_pc_o    = fetch_q[PC_W-1:0];

  // Control part of decode/execute register with empty-slot insertion.
  assign ctrl_d = {dec_ex_ctrl_i, dec_mem_ctrl_i, dec_wb_ctrl_i};

  lus_bubble_reg #(.W(CTRL_W)) i_idex_ctrl_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill_i (stall_o),
    .d_i    (ctrl_d),
    .q_o    (ctrl_q)
  );

  assign idex_ex_ctrl_o  = ctrl_q[CTRL_W-1:MEM_CTRL_W+WB_CTRL_W];
  assign idex_mem_ctrl_o = ctrl_q[MEM_CTRL_W+WB_CTRL_W-1:WB_CTRL_W];
  assign idex_wb_ctrl_o  = ctrl_q[WB_CTRL_W-1:0];

  // R2: a stall never appears without a load in the execute stage.
  assert_stall_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> ld_mem_read_i);

  // R3: PC frozen across a stall edge.
  assert_pc_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> $stable(pc_o));

  // R4: fetch/decode register frozen across a stall edge.
  assert_ifid_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> ($stable(ifid_instr_o) && $stable(ifid_pc_o)));

  // R5: every control output is cleared after a stall edge.
  assert_bubble_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> ({idex_ex_ctrl_o, idex_mem_ctrl_o, idex_wb_ctrl_o} == '0));

  // R6: without a stall the PC follows the next address.
  assert_pc_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |=> (pc_o == $past(pc_next_i)));

  // R6: without a stall the fetch address follows the old PC.
  assert_ifid_pc_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |=> (ifid_pc_o == $past(pc_o)));
endmodule

// File: tb/test_load_use_stall_ctrl.sv
module test_load_use_stall_ctrl;
  logic        clk;
  logic        rst_n;
  logic        ld_mem_read_i;
  logic [4:0]  ld_dest_i;
  logic [4:0]  dec_src_a_i;
  logic [4:0]  dec_src_b_i;
  logic [31:0] pc_next_i;
  logic [31:0] fetch_instr_i;
  logic [3:0]  dec_ex_ctrl_i;
  logic [2:0]  dec_mem_ctrl_i;
  logic [1:0]  dec_wb_ctrl_i;
  logic [31:0] pc_o;
  logic [31:0] ifid_instr_o;
  logic [31:0] ifid_pc_o;
  logic [3:0]  idex_ex_ctrl_o;
  logic [2:0]  idex_mem_ctrl_o;
  logic [1:0]  idex_wb_ctrl_o;
  logic        stall_o;

  int checks = 0;
  int errors = 0;

  load_use_stall_ctrl i_load_use_stall_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_mem_read_i(ld_mem_read_i), .ld_dest_i(ld_dest_i),
    .dec_src_a_i(dec_src_a_i), .dec_src_b_i(dec_src_b_i),
    .pc_next_i(pc_next_i), .fetch_instr_i(fetch_instr_i),
    .dec_ex_ctrl_i(dec_ex_ctrl_i), .dec_mem_ctrl_i(dec_mem_ctrl_i),
    .dec_wb_ctrl_i(dec_wb_ctrl_i),
    .pc_o(pc_o), .ifid_instr_o(ifid_instr_o), .ifid_pc_o(ifid_pc_o),
    .idex_ex_ctrl_o(idex_ex_ctrl_o), .idex_mem_ctrl_o(idex_mem_ctrl_o),
    .idex_wb_ctrl_o(idex_wb_ctrl_o), .stall_o(stall_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge.
  task automatic drive(input logic mr, input logic [4:0] dst, input logic [4:0] sa,
                       input logic [4:0] sb, input logic [31:0] npc,
                       input logic [31:0] ins, input logic [8:0] ctl);
    @(negedge clk);
    ld_mem_read_i = mr; ld_dest_i = dst; dec_src_a_i = sa; dec_src_b_i = sb;
    pc_next_i = npc; fetch_instr_i = ins;
    {dec_ex_ctrl_i, dec_mem_ctrl_i, dec_wb_ctrl_i} = ctl;
    #1;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b0, 5'd0, 5'd1, 5'd2, 32'h1111_0000, 32'hAAAA_5555, 9'h1FF);
    settle();
    chk("R1 pc", pc_o, 0);
    chk("R1 ifid instr", ifid_instr_o, 0);
    chk("R1 ifid pc", ifid_pc_o, 0);
    chk("R1 ctrl", {idex_ex_ctrl_o, idex_mem_ctrl_o, idex_wb_ctrl_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pc after release", pc_o, 0);
  endtask

  task automatic t_flow();
    logic [31:0] old_pc;
    drive(1'b0, 5'd4, 5'd4, 5'd9, 32'h0000_0104, 32'h1234_5678, 9'h0A5);
    chk("R2 no load no stall", stall_o, 0);
    old_pc = pc_o;
    settle();
    chk("R6 pc load", pc_o, 32'h0000_0104);
    chk("R6 ifid instr", ifid_instr_o, 32'h1234_5678);
    chk("R6 ifid pc", ifid_pc_o, old_pc);
    chk("R6 ctrl", {idex_ex_ctrl_o, idex_mem_ctrl_o, idex_wb_ctrl_o}, 9'h0A5);
    drive(1'b1, 5'd3, 5'd4, 5'd9, 32'h0000_0108, 32'h9ABC_DEF0, 9'h15A);
    chk("R2 load no match", stall_o, 0);
    settle();
    chk("R6 pc load 2", pc_o, 32'h0000_0108);
    chk("R6 ifid pc 2", ifid_pc_o, 32'h0000_0104);
  endtask

  task automatic t_stall(input string tag, input logic [4:0] dst,
                         input logic [4:0] sa, input logic [4:0] sb);
    logic [31:0] p, i, ip;
    p = pc_o; i = ifid_instr_o; ip = ifid_pc_o;
    drive(1'b1, dst, sa, sb, 32'hDEAD_0000, 32'hFEED_BEEF, 9'h1FF);
    chk({tag, " R2 stall"}, stall_o, 1);
    settle();
    chk({tag, " R3 pc held"}, pc_o, p);
    chk({tag, " R4 instr held"}, ifid_instr_o, i);
    chk({tag, " R4 pc held"}, ifid_pc_o, ip);
    chk({tag, " R5 bubble"}, {idex_ex_ctrl_o, idex_mem_ctrl_o, idex_wb_ctrl_o}, 0);
  endtask

  task automatic t_zero_index();
    t_stall("R7 idx0", 5'd0, 5'd0, 5'd12);
  endtask

  task automatic t_back_to_back();
    int stalls = 0;
    // Load (dest 7) in execute, first user in decode.
    drive(1'b1, 5'd7, 5'd7, 5'd2, 32'h0000_0200, 32'h0000_0A01, 9'h033);
    stalls += stall_o;
    settle();
    // Empty slot in execute, same user still in decode.
    drive(1'b0, 5'd0, 5'd7, 5'd2, 32'h0000_0200, 32'h0000_0A01, 9'h033);
    chk("R8 first user released", stall_o, 0);
    stalls += stall_o;
    settle();
    chk("R8 pc advances", pc_o, 32'h0000_0200);
    chk("R8 ctrl loaded", {idex_ex_ctrl_o, idex_mem_ctrl_o, idex_wb_ctrl_o}, 9'h033);
    // First user in execute (no memory read), second user in decode.
    drive(1'b0, 5'd9, 5'd7, 5'd7, 32'h0000_0204, 32'h0000_0A02, 9'h044);
    stalls += stall_o;
    settle();
    chk("R8 single stall cycle", stalls, 1);
    chk("R8 second user advances", pc_o, 32'h0000_0204);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_flow();
    t_stall("src a", 5'd5, 5'd5, 5'd6);
    t_stall("src b", 5'd31, 5'd1, 5'd31);
    t_stall("both", 5'd8, 5'd8, 5'd8);
    // Matching indices without a memory read: no stall.
    drive(1'b0, 5'd8, 5'd8, 5'd8, 32'h0000_0300, 32'h0, 9'h0);
    chk("R2 match without read", stall_o, 0);
    settle();
    t_zero_index();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule